// File: doc/BRIEF.md
# Sampling Delay Tuning Sequencer

This block searches for a good sampling-clock delay for a high-speed SD host. After a start pulse it tries 7-bit delay codes one at a time. For each code it waits a programmable settling time and then asks the data path for one tuning read. The data path answers with a completion strobe and two error flags. The sequencer first looks for the lowest code that passes. It then walks upward to find the last passing code of that window. Finally it programs the midpoint of the window, checks that code once more, and reports the outcome.

During the search the sequencer holds the execute-tuning, sample-clock-select and feedback-clock-select controls high. None of these controls clear on their own. At the end only the execute-tuning control is dropped. The chosen code stays on the delay output and in the tuning-control word until the next run.

Top module: `dly_tune_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `tunePass`, `trialReq`, the three mode controls and `delayCode` are all 0.
- R2: The lower search starts at code 0 and rises in steps of 1. It stops at the first code whose trial passes, and that code becomes the lower bound. Codes 0 to 126 are tried. If none of them passes, the lower bound is 127 and code 127 is not tried in this phase.
- R3: The upper search starts one code above the lower bound and rises in steps of 1. On the first failing trial, the upper bound is the failing code minus 1. If code 126 passes, or the lower bound is already 126 or higher, the upper bound is 127.
- R4: The last trial uses code floor((lower+upper)/2). Its outcome is presented on `tunePass` (1 = pass), and that code stays on `delayCode`.
- R5: A trial counts as failed when `cmdErr` or `dataErr` is 1 in the cycle where `trialDone` is 1. It passes only when both are 0.
- R6: Before each trial there is a settling wait of `settleCycles`+1 cycles. `trialReq` rises `settleCycles`+2 cycles after the cycle that sampled the start pulse or the previous `trialDone`. The final trial comes one cycle later than this, because the midpoint is computed first.
- R7: While any trial is requested, `execTune`, `smpClkSel` and `fbClkSel` are all 1, and `tuneWord` equals `delayCode` placed at bits [14:8] with every other bit 0. After the run, `execTune` is 0 while `smpClkSel` and `fbClkSel` stay 1.
- R8: `trialReq` is a one-cycle pulse. The sequencer then waits for `trialDone` for as long as it takes, with no timeout.
- R9: `done` is a one-cycle pulse in the cycle where `busy` falls. After it, `delayCode` and `tunePass` stay unchanged while the block is idle.
- R10: A start pulse that arrives while `busy` is 1 has no effect. The trial sequence and the final code are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only while idle |
| settleCycles | input | 16 | Length of the settling wait before each trial, minus one |
| trialReq | output | 1 | One-cycle request for a tuning read |
| trialDone | input | 1 | Tuning read finished; error flags are valid in this cycle |
| cmdErr | input | 1 | The tuning read reported a command error |
| dataErr | input | 1 | The tuning read reported a data error |
| delayCode | output | 7 | Delay code currently applied |
| tuneWord | output | 16 | Tuning-control word with the code at bits [14:8] |
| execTune | output | 1 | Execute-tuning control |
| smpClkSel | output | 1 | Use the tuned sampling clock |
| fbClkSel | output | 1 | Use the feedback clock |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle end-of-run pulse |
| tunePass | output | 1 | Outcome of the final midpoint trial |

## Verification
A request is due exactly `settleCycles`+2 cycles after the cycle that sampled the start or the previous completion, and the final trial is due one cycle later than that. The bench records the cycle in which it drives each completion. When a request appears, it compares the elapsed cycles against the expected value for that trial. It reads each request, together with its code and mode controls, on the falling edge of the request cycle. It checks `done` and its companion outputs on the falling edge after the edge that sampled the final completion, and checks them again one cycle later to confirm the pulse has ended and the values are held.

// File: rtl/dly_tune_pkg.sv
package dly_tune_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRun;   // code <= 0, raise mode controls
    logic incCode;    // code <= code + 1
    logic latchLo;    // lower bound <= code
    logic loMax;      // lower bound <= top code
    logic hiMax;      // upper bound <= top code
    logic hiPrev;     // upper bound <= code - 1
    logic loadMid;    // code <= (lower + upper) / 2
    logic loadSettle; // settle counter <= settleCycles
    logic decSettle;  // settle counter - 1
    logic latchRes;   // capture final outcome
    logic clrExec;    // drop execute-tuning control
  } tuneCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_REQ, ST_WAIT, ST_MID
  } tuneState_t;

  typedef enum logic [1:0] {
    PH_LOW, PH_HIGH, PH_FIN
  } tunePhase_t;

endpackage

// File: rtl/dly_tune_dp.sv
module dly_tune_dp
  import dly_tune_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tuneCmd_t            cmd,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                trialPass,
  output logic [CODE_W-1:0]   code,
  output logic                lastStep,
  output logic                settleZero,
  output logic                execTune,
  output logic                smpClkSel,
  output logic                fbClkSel,
  output logic                resPass
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  logic [CODE_W-1:0]   loBound, hiBound;
  logic [SETTLE_W-1:0] settleCnt;
  logic [CODE_W:0]     boundSum;

  assign boundSum   = {1'b0, loBound} + {1'b0, hiBound};
  assign lastStep   = (code >= CODE_MAX - CODE_ONE);
  assign settleZero = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code      <= '0;
      loBound   <= '0;
      hiBound   <= '0;
      settleCnt <= '0;
      execTune  <= 1'b0;
      smpClkSel <= 1'b0;
      fbClkSel  <= 1'b0;
      resPass   <= 1'b0;
    end else begin
      if (cmd.clearRun) begin
        code      <= '0;
        execTune  <= 1'b1;
        smpClkSel <= 1'b1;
        fbClkSel  <= 1'b1;
      end else if (cmd.incCode) begin
        code <= code + CODE_ONE;
      end else if (cmd.loadMid) begin
        code <= boundSum[CODE_W:1];
      end
      if (cmd.loMax)        loBound <= CODE_MAX;
      else if (cmd.latchLo) loBound <= code;
      if (cmd.hiMax)        hiBound <= CODE_MAX;
      else if (cmd.hiPrev)  hiBound <= code - CODE_ONE;
      if (cmd.loadSettle)     settleCnt <= settleCycles;
      else if (cmd.decSettle) settleCnt <= settleCnt - SETTLE_W'(1);
      if (cmd.latchRes) resPass  <= trialPass;
      if (cmd.clrExec)  execTune <= 1'b0;
    end
  end

endmodule

// File: rtl/dly_tune_ctl.sv
module dly_tune_ctl
  import dly_tune_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     trialDone,
  input  logic     trialPass,
  input  logic     lastStep,
  input  logic     settleZero,
  output tuneCmd_t cmd,
  output logic     trialReq,
  output logic     busy,
  output logic     done
);

  tuneState_t state, stateNxt;
  tunePhase_t phase, phaseNxt;

  assign trialReq = (state == ST_REQ);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    phaseNxt = phase;
    unique case (state)
      ST_IDLE: if (start) begin
        cmd.clearRun   = 1'b1;
        cmd.loadSettle = 1'b1;
        phaseNxt       = PH_LOW;
        stateNxt       = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleZero) stateNxt = ST_REQ;
        else            cmd.decSettle = 1'b1;
      end
      ST_REQ: stateNxt = ST_WAIT;
      ST_WAIT: if (trialDone) begin
        unique case (phase)
          PH_LOW: begin
            if (trialPass) cmd.latchLo = 1'b1;
            if (trialPass && lastStep) begin
              cmd.hiMax = 1'b1;
              stateNxt  = ST_MID;
            end else if (lastStep) begin
              cmd.loMax = 1'b1;
              cmd.hiMax = 1'b1;
              stateNxt  = ST_MID;
            end else begin
              cmd.incCode    = 1'b1;
              cmd.loadSettle = 1'b1;
              stateNxt       = ST_SETTLE;
              if (trialPass) phaseNxt = PH_HIGH;
            end
          end
          PH_HIGH: begin
            if (!trialPass) begin
              cmd.hiPrev = 1'b1;
              stateNxt   = ST_MID;
            end else if (lastStep) begin
              cmd.hiMax = 1'b1;
              stateNxt  = ST_MID;
            end else begin
              cmd.incCode    = 1'b1;
              cmd.loadSettle = 1'b1;
              stateNxt       = ST_SETTLE;
            end
          end
          default: begin
            cmd.latchRes = 1'b1;
            cmd.clrExec  = 1'b1;
            stateNxt     = ST_IDLE;
          end
        endcase
      end
      ST_MID: begin
        cmd.loadMid    = 1'b1;
        cmd.loadSettle = 1'b1;
        phaseNxt       = PH_FIN;
        stateNxt       = ST_SETTLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_LOW;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
      done  <= cmd.latchRes;
    end
  end

endmodule

// File: rtl/dly_tune_engine.sv
module dly_tune_engine
  import dly_tune_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int CODE_LSB = 8,
  parameter int WORD_W   = 16,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                trialReq,
  input  logic                trialDone,
  input  logic                cmdErr,
  input  logic                dataErr,
  output logic [CODE_W-1:0]   delayCode,
  output logic [WORD_W-1:0]   tuneWord,
  output logic                execTune,
  output logic                smpClkSel,
  output logic                fbClkSel,
  output logic                busy,
  output logic                done,
  output logic                tunePass
);

  tuneCmd_t cmd;
  logic     trialPass, lastStep, settleZero;

  assign trialPass = !(cmdErr || dataErr);
  assign tuneWord  = WORD_W'(delayCode) << CODE_LSB;

  dly_tune_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .trialDone(trialDone),
    .trialPass(trialPass), .lastStep(lastStep), .settleZero(settleZero),
    .cmd(cmd), .trialReq(trialReq), .busy(busy), .done(done)
  );

  dly_tune_dp #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .settleCycles(settleCycles),
    .trialPass(trialPass), .code(delayCode), .lastStep(lastStep),
    .settleZero(settleZero), .execTune(execTune), .smpClkSel(smpClkSel),
    .fbClkSel(fbClkSel), .resPass(tunePass)
  );

endmodule

// File: rtl/dly_tune_chk.sv
module dly_tune_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              trialReq,
  input logic              busy,
  input logic              done,
  input logic              execTune,
  input logic              smpClkSel,
  input logic              fbClkSel,
  input logic              tunePass,
  input logic [CODE_W-1:0] delayCode
);

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    trialReq |=> !trialReq);

  p_req_in_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    trialReq |-> busy);

  p_modes_on_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    trialReq |-> (execTune && smpClkSel && fbClkSel));

  p_exec_dropped_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!execTune && smpClkSel && fbClkSel));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(delayCode) && $stable(tunePass)));

endmodule

bind dly_tune_engine dly_tune_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .trialReq(trialReq), .busy(busy), .done(done),
  .execTune(execTune), .smpClkSel(smpClkSel), .fbClkSel(fbClkSel),
  .tunePass(tunePass), .delayCode(delayCode)
);

// File: tb/dly_tune_engine_tb.sv
module dly_tune_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] settleCycles = 16'd0;
  logic        trialReq;
  logic        trialDone = 1'b0;
  logic        cmdErr = 1'b0;
  logic        dataErr = 1'b0;
  logic [6:0]  delayCode;
  logic [15:0] tuneWord;
  logic        execTune, smpClkSel, fbClkSel, busy, done, tunePass;

  dly_tune_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .trialReq(trialReq), .trialDone(trialDone), .cmdErr(cmdErr),
    .dataErr(dataErr), .delayCode(delayCode), .tuneWord(tuneWord),
    .execTune(execTune), .smpClkSel(smpClkSel), .fbClkSel(fbClkSel),
    .busy(busy), .done(done), .tunePass(tunePass)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0, cyc = 0;
  int wLo, wHi, respLat, settleN, totalTrials, trialIdx, doneCyc;
  bit failLast;
  int expQ[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit inWin(int c);
    return (c >= wLo) && (c <= wHi);
  endfunction

  // driver-side model: push expected trial codes
  task automatic buildExpect(output int fCode, output bit fPass);
    int lo, hi;
    expQ.delete();
    lo = 0;
    while (lo < 127) begin
      expQ.push_back(lo);
      if (inWin(lo)) break;
      lo++;
    end
    hi = lo + 1;
    while (hi < 127) begin
      expQ.push_back(hi);
      if (!inWin(hi)) begin hi--; break; end
      hi++;
    end
    if (hi > 127) hi = 127;
    fCode = (lo + hi) / 2;
    expQ.push_back(fCode);
    fPass = inWin(fCode) && !failLast;
    totalTrials = expQ.size();
  endtask

  // monitor and responder
  initial begin
    forever begin
      int code, e, gap;
      bit ok;
      @(negedge clk);
      if (trialReq) begin
        code = int'(delayCode);
        gap  = cyc - doneCyc;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected trial", code, -1);
        end else begin
          e = expQ.pop_front();
          chk(code == e, "R2", "trial code", code, e);
          chk(gap == settleN + 2 + ((expQ.size() == 0) ? 1 : 0), "R6",
              "settle gap", gap, settleN + 2 + ((expQ.size() == 0) ? 1 : 0));
        end
        chk(execTune && smpClkSel && fbClkSel, "R7", "modes on request",
            {execTune, smpClkSel, fbClkSel}, 7);
        chk(tuneWord == (16'(code) << 8), "R7", "tuneWord", tuneWord, code << 8);
        ok = inWin(code) && !(failLast && trialIdx == totalTrials - 1);
        trialIdx++;
        repeat (respLat) @(negedge clk);
        chk(!trialReq, "R8", "request held", trialReq, 0);
        trialDone = 1'b1;
        cmdErr    = !ok && code[0];
        dataErr   = !ok && !code[0];
        doneCyc   = cyc;
        @(negedge clk);
        trialDone = 1'b0;
        cmdErr    = 1'b0;
        dataErr   = 1'b0;
      end
    end
  end

  task automatic runCase(string tag, int lo, int hi, bit fl, int lat, int st, bit poke);
    int fCode, held, iter;
    bit fPass;
    wLo = lo; wHi = hi; failLast = fl; respLat = lat; settleN = st;
    trialIdx = 0;
    buildExpect(fCode, fPass);
    settleCycles = 16'(st);
    @(negedge clk);
    start   = 1'b1;
    doneCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", {tag, " busy after start"}, busy, 1);
    iter = 0;
    while (!done) begin
      @(negedge clk);
      iter++;
      if (poke && iter == 20) start = 1'b1;  // R10: start while busy
      if (poke && iter == 21) start = 1'b0;
    end
    chk(expQ.size() == 0, "R2", {tag, " trials left"}, expQ.size(), 0);
    chk(delayCode == 7'(fCode), "R4", {tag, " final code"}, delayCode, fCode);
    chk(tunePass == fPass, "R4", {tag, " final pass"}, tunePass, fPass);
    chk(!busy, "R9", {tag, " busy at done"}, busy, 0);
    chk(!execTune && smpClkSel && fbClkSel, "R7", {tag, " modes after run"},
        {execTune, smpClkSel, fbClkSel}, 3);
    held = int'(delayCode);
    @(negedge clk);
    chk(!done, "R9", {tag, " done pulse width"}, done, 0);
    repeat (3) @(negedge clk);
    chk(int'(delayCode) == held && tunePass == fPass, "R9", {tag, " held code"},
        delayCode, held);
  endtask

  initial begin
    doneCyc = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tunePass && !trialReq, "R1", "reset flags",
        {busy, done, tunePass, trialReq}, 0);
    chk(!execTune && !smpClkSel && !fbClkSel, "R1", "reset modes",
        {execTune, smpClkSel, fbClkSel}, 0);
    chk(delayCode == 7'd0, "R1", "reset code", delayCode, 0);
    rstN = 1'b1;
    @(negedge clk);
    runCase("mid window R3", 20, 40, 1'b0, 2, 3, 1'b0);
    runCase("window at zero R3", 0, 0, 1'b0, 1, 0, 1'b0);
    runCase("window to top R3", 100, 127, 1'b0, 3, 2, 1'b0);
    runCase("no pass R2", 1, 0, 1'b0, 1, 1, 1'b0);
    runCase("top pair R3", 126, 127, 1'b0, 1, 0, 1'b0);
    runCase("final fail R5 R10", 50, 60, 1'b1, 40, 4, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule